// File: doc/BRIEF.md
# Character I/O Port with Flag-Driven Interrupt

This block sits between a small accumulator processor and two character devices. The input device deposits one character at a time into a holding register. The processor later moves that character into its accumulator. In the other direction, the processor writes one accumulator character into an output holding register, and the output device then takes it. Each direction has a single ready flag, and that flag decides who may touch the register next.

The input flag rises when a new character has arrived. While it is high, the register is locked against the device. The output flag is high when the device has taken the last character. While it is low, the register is locked against the processor. The processor can test either flag with a skip strobe. It can also enable or disable interrupts with dedicated strobes. When interrupts are enabled and either flag is high, an interrupt request is raised. The enable clears itself when the processor signals entry into the interrupt cycle.

Top module: `char_io_irq_port`

## Requirements
- R1: After a synchronous reset, the input flag is 0 (`in_dev_ready`=1), the output flag is 1 (`out_dev_valid`=0), the interrupt enable is 0 (`irq`=0), `wr_err`=0, and both holding registers are 0.
- R2: When `in_dev_valid` is 1 while `in_dev_ready` is 1, `cpu_in_data` holds the offered character from the next cycle on, and `in_dev_ready` drops to 0 in that cycle.
- R3: While `in_dev_ready` is 0, offers from the input device are refused and `cpu_in_data` keeps its value.
- R4: A `cpu_in_take` strobe while the input flag is 1 returns `in_dev_ready` to 1 on the next cycle. A take strobe while the flag is 0 has no effect.
- R5: A `cpu_out_write` strobe while `out_dev_valid` is 0 loads `cpu_acc` into `out_dev_data` and sets `out_dev_valid` to 1 on the next cycle.
- R6: A `cpu_out_write` strobe while `out_dev_valid` is 1 leaves `out_dev_data` and the flag unchanged, and it makes `wr_err` 1 for exactly the next cycle. `wr_err` is 0 at every other time.
- R7: `out_dev_accept` while `out_dev_valid` is 1 drops `out_dev_valid` on the next cycle. While `out_dev_valid` is 0, the accept strobe has no effect.
- R8: `irq` equals the interrupt enable ANDed with (input flag OR output flag), with no added delay.
- R9: `cpu_ien_set` sets the enable on the next cycle. `cpu_ien_clr` and `cpu_irq_ack` clear it on the next cycle, and each of them wins over a simultaneous set.
- R10: `cpu_skip` equals (`cpu_skip_in` AND input flag) OR (`cpu_skip_out` AND output flag), in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_acc | input | DATA_W | Accumulator value for output writes |
| cpu_in_take | input | 1 | Strobe: move the input character to the accumulator |
| cpu_out_write | input | 1 | Strobe: write the accumulator to the output register |
| cpu_ien_set | input | 1 | Strobe: enable interrupts |
| cpu_ien_clr | input | 1 | Strobe: disable interrupts |
| cpu_irq_ack | input | 1 | Interrupt cycle entered; clears the enable |
| cpu_skip_in | input | 1 | Skip test on the input flag |
| cpu_skip_out | input | 1 | Skip test on the output flag |
| cpu_in_data | output | DATA_W | Input holding register |
| cpu_skip | output | 1 | Skip condition for the active test |
| irq | output | 1 | Interrupt request |
| wr_err | output | 1 | One-cycle pulse on a blocked output write |
| in_dev_valid | input | 1 | Input device offers a character |
| in_dev_data | input | DATA_W | Offered character |
| in_dev_ready | output | 1 | Inverse of the input flag |
| out_dev_valid | output | 1 | Inverse of the output flag |
| out_dev_data | output | DATA_W | Output holding register |
| out_dev_accept | input | 1 | Output device takes the character |

## Verification
Directed sequences come first. They offer characters to a locked input register and write to a locked output register. They also issue set and clear strobes in the same cycle and send an acknowledge while a request is pending. These cases separate correct refusal from silent overwrite, and they show which enable command has priority. A long seeded random phase follows. It mixes device offers, takes, writes, accepts, skip tests and enable strobes at uneven rates, so both flags and the enable pass through every combination. That phase distinguishes a request driven by the input flag from one driven by the output flag, and it catches same-cycle hand-offs between the two sides of a register.

// File: rtl/chario_pkg.sv
package chario_pkg;

    typedef enum logic [1:0] {
        IEN_HOLD = 2'd0,
        IEN_ON   = 2'd1,
        IEN_OFF  = 2'd2
    } ien_cmd_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic ack;
    } ien_req_t;

    typedef struct packed {
        logic in_test;
        logic out_test;
    } skip_req_t;

    // Clear and acknowledge outrank set.
    function automatic ien_cmd_e ien_decode(input ien_req_t r);
        if (r.clr || r.ack) return IEN_OFF;
        if (r.set)          return IEN_ON;
        return IEN_HOLD;
    endfunction

    function automatic logic irq_level(input logic en, input logic fin, input logic fout);
        return en & (fin | fout);
    endfunction

    function automatic logic skip_hit(input skip_req_t s, input logic fin, input logic fout);
        return (s.in_test & fin) | (s.out_test & fout);
    endfunction

endpackage

// File: rtl/chario_in_chan.sv
module chario_in_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dev_valid,
    input  logic [W-1:0] dev_data,
    input  logic         take,
    output logic         flag,
    output logic [W-1:0] hold
);
    logic load;
    assign load = dev_valid & ~flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            hold <= '0;
        end else if (load) begin
            flag <= 1'b1;
            hold <= dev_data;
        end else if (take && flag) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/chario_out_chan.sv
module chario_out_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         write,
    input  logic [W-1:0] acc,
    input  logic         dev_accept,
    output logic         flag,
    output logic [W-1:0] hold,
    output logic         err
);
    logic do_write;
    logic blocked;
    assign do_write = write & flag;
    assign blocked  = write & ~flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b1;
            hold <= '0;
            err  <= 1'b0;
        end else begin
            err <= blocked;
            if (do_write) begin
                flag <= 1'b0;
                hold <= acc;
            end else if (dev_accept && !flag) begin
                flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/chario_irq_ctl.sv
module chario_irq_ctl
    import chario_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ien_req_t req,
    input  logic     fin,
    input  logic     fout,
    output logic     en,
    output logic     irq
);
    ien_cmd_e cmd;
    assign cmd = ien_decode(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else begin
            unique case (cmd)
                IEN_ON:  en <= 1'b1;
                IEN_OFF: en <= 1'b0;
                default: en <= en;
            endcase
        end
    end

    assign irq = irq_level(en, fin, fout);
endmodule

// File: rtl/char_io_irq_port.sv
module char_io_irq_port
    import chario_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] cpu_acc,
    input  logic              cpu_in_take,
    input  logic              cpu_out_write,
    input  logic              cpu_ien_set,
    input  logic              cpu_ien_clr,
    input  logic              cpu_irq_ack,
    input  logic              cpu_skip_in,
    input  logic              cpu_skip_out,
    output logic [DATA_W-1:0] cpu_in_data,
    output logic              cpu_skip,
    output logic              irq,
    output logic              wr_err,
    input  logic              in_dev_valid,
    input  logic [DATA_W-1:0] in_dev_data,
    output logic              in_dev_ready,
    output logic              out_dev_valid,
    output logic [DATA_W-1:0] out_dev_data,
    input  logic              out_dev_accept
);
    logic      in_flag;
    logic      out_flag;
    logic      ien_q;
    ien_req_t  ien_req;
    skip_req_t skip_req;

    assign ien_req  = '{set: cpu_ien_set, clr: cpu_ien_clr, ack: cpu_irq_ack};
    assign skip_req = '{in_test: cpu_skip_in, out_test: cpu_skip_out};

    chario_in_chan #(.W(DATA_W)) u_in (
        .clk       (clk),
        .rst       (rst),
        .dev_valid (in_dev_valid),
        .dev_data  (in_dev_data),
        .take      (cpu_in_take),
        .flag      (in_flag),
        .hold      (cpu_in_data)
    );

    chario_out_chan #(.W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .write      (cpu_out_write),
        .acc        (cpu_acc),
        .dev_accept (out_dev_accept),
        .flag       (out_flag),
        .hold       (out_dev_data),
        .err        (wr_err)
    );

    chario_irq_ctl u_irq (
        .clk  (clk),
        .rst  (rst),
        .req  (ien_req),
        .fin  (in_flag),
        .fout (out_flag),
        .en   (ien_q),
        .irq  (irq)
    );

    assign in_dev_ready  = ~in_flag;
    assign out_dev_valid = ~out_flag;
    assign cpu_skip      = skip_hit(skip_req, in_flag, out_flag);
endmodule

// File: rtl/chario_port_checker.sv
module chario_port_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cpu_acc,
    input logic         cpu_in_take,
    input logic         cpu_out_write,
    input logic         cpu_ien_set,
    input logic         cpu_ien_clr,
    input logic         cpu_irq_ack,
    input logic [W-1:0] cpu_in_data,
    input logic         irq,
    input logic         wr_err,
    input logic         in_dev_valid,
    input logic [W-1:0] in_dev_data,
    input logic         in_dev_ready,
    input logic         out_dev_valid,
    input logic [W-1:0] out_dev_data,
    input logic         out_dev_accept,
    input logic         ien
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (in_dev_ready && !out_dev_valid && !ien && !wr_err));

    assert_in_load_R2: assert property (@(posedge clk) disable iff (rst)
        (in_dev_valid && in_dev_ready) |=> (!in_dev_ready && cpu_in_data == $past(in_dev_data)));

    assert_in_locked_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_dev_ready && !cpu_in_take) |=> (!in_dev_ready && $stable(cpu_in_data)));

    assert_in_take_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_in_take && !in_dev_ready) |=> in_dev_ready);

    assert_out_write_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_out_write && !out_dev_valid) |=> (out_dev_valid && out_dev_data == $past(cpu_acc)));

    assert_out_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_out_write && out_dev_valid) |=> (wr_err && $stable(out_dev_data)));

    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !(cpu_out_write && out_dev_valid) |=> !wr_err);

    assert_out_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (out_dev_accept && out_dev_valid) |=> !out_dev_valid);

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
        irq == (ien && (!in_dev_ready || !out_dev_valid)));

    assert_ien_off_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_ien_clr || cpu_irq_ack) |=> !ien);

    assert_ien_on_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_ien_set && !cpu_ien_clr && !cpu_irq_ack) |=> ien);
endmodule

bind char_io_irq_port chario_port_checker #(.W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_acc        (cpu_acc),
    .cpu_in_take    (cpu_in_take),
    .cpu_out_write  (cpu_out_write),
    .cpu_ien_set    (cpu_ien_set),
    .cpu_ien_clr    (cpu_ien_clr),
    .cpu_irq_ack    (cpu_irq_ack),
    .cpu_in_data    (cpu_in_data),
    .irq            (irq),
    .wr_err         (wr_err),
    .in_dev_valid   (in_dev_valid),
    .in_dev_data    (in_dev_data),
    .in_dev_ready   (in_dev_ready),
    .out_dev_valid  (out_dev_valid),
    .out_dev_data   (out_dev_data),
    .out_dev_accept (out_dev_accept),
    .ien            (ien_q)
);

// File: tb/sim_char_io_irq_port.sv
`timescale 1ns/1ps
module sim_char_io_irq_port;
    localparam int W = 8;
    localparam int MAX_CYC = 200000;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] cpu_acc;
    logic         cpu_in_take, cpu_out_write;
    logic         cpu_ien_set, cpu_ien_clr, cpu_irq_ack;
    logic         cpu_skip_in, cpu_skip_out;
    logic [W-1:0] cpu_in_data;
    logic         cpu_skip, irq, wr_err;
    logic         in_dev_valid;
    logic [W-1:0] in_dev_data;
    logic         in_dev_ready, out_dev_valid;
    logic [W-1:0] out_dev_data;
    logic         out_dev_accept;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model of the port
    logic         m_fi, m_fo, m_en, m_err;
    logic [W-1:0] m_in, m_out;

    always #2.5 clk = ~clk;

    char_io_irq_port #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .cpu_acc(cpu_acc),
        .cpu_in_take(cpu_in_take), .cpu_out_write(cpu_out_write),
        .cpu_ien_set(cpu_ien_set), .cpu_ien_clr(cpu_ien_clr), .cpu_irq_ack(cpu_irq_ack),
        .cpu_skip_in(cpu_skip_in), .cpu_skip_out(cpu_skip_out),
        .cpu_in_data(cpu_in_data), .cpu_skip(cpu_skip), .irq(irq), .wr_err(wr_err),
        .in_dev_valid(in_dev_valid), .in_dev_data(in_dev_data), .in_dev_ready(in_dev_ready),
        .out_dev_valid(out_dev_valid), .out_dev_data(out_dev_data),
        .out_dev_accept(out_dev_accept)
    );

    function automatic logic exp_irq(logic en, logic fi, logic fo);
        return en && (fi || fo);
    endfunction

    function automatic logic exp_skip(logic si, logic so, logic fi, logic fo);
        return (si && fi) || (so && fo);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cpu_acc = '0; cpu_in_take = 0; cpu_out_write = 0;
        cpu_ien_set = 0; cpu_ien_clr = 0; cpu_irq_ack = 0;
        cpu_skip_in = 0; cpu_skip_out = 0;
        in_dev_valid = 0; in_dev_data = '0; out_dev_accept = 0;
    endtask

    task automatic check_all();
        chk("R2 R3 R4 in_dev_ready", 32'(in_dev_ready), 32'(!m_fi));
        chk("R5 R7 out_dev_valid", 32'(out_dev_valid), 32'(!m_fo));
        chk("R2 R3 cpu_in_data", 32'(cpu_in_data), 32'(m_in));
        chk("R5 R6 out_dev_data", 32'(out_dev_data), 32'(m_out));
        chk("R8 R9 irq", 32'(irq), 32'(exp_irq(m_en, m_fi, m_fo)));
        chk("R10 cpu_skip", 32'(cpu_skip), 32'(exp_skip(cpu_skip_in, cpu_skip_out, m_fi, m_fo)));
        chk("R6 wr_err", 32'(wr_err), 32'(m_err));
    endtask

    // inputs are stable here (driven after the falling edge)
    task automatic tick();
        #1;
        check_all();
        @(posedge clk);
        cyc++;
        if (rst) begin
            m_fi = 0; m_fo = 1; m_en = 0; m_err = 0; m_in = '0; m_out = '0;
        end else begin
            m_err = cpu_out_write && !m_fo;
            if (in_dev_valid && !m_fi) begin
                m_fi = 1; m_in = in_dev_data;
            end else if (cpu_in_take && m_fi) begin
                m_fi = 0;
            end
            if (cpu_out_write && m_fo) begin
                m_fo = 0; m_out = cpu_acc;
            end else if (out_dev_accept && !m_fo) begin
                m_fo = 1;
            end
            if (cpu_ien_clr || cpu_irq_ack) m_en = 0;
            else if (cpu_ien_set) m_en = 1;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        m_fi = 0; m_fo = 1; m_en = 0; m_err = 0; m_in = '0; m_out = '0;
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R1: reset state at the ports
        #1;
        chk("R1 in_dev_ready", 32'(in_dev_ready), 32'd1);
        chk("R1 out_dev_valid", 32'(out_dev_valid), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 wr_err", 32'(wr_err), 32'd0);

        // R2 load, then R3 refused overwrite
        in_dev_valid = 1; in_dev_data = 8'h41; tick();
        in_dev_valid = 1; in_dev_data = 8'h5A; tick();
        #1 chk("R3 held char", 32'(cpu_in_data), 32'h41);
        // R4: take returns ready, take with flag low ignored
        cpu_in_take = 1; tick();
        cpu_in_take = 1; tick();
        #1 chk("R4 ready after take", 32'(in_dev_ready), 32'd1);

        // R5 write, R6 blocked write with error pulse, R7 accept
        cpu_out_write = 1; cpu_acc = 8'hC3; tick();
        cpu_out_write = 1; cpu_acc = 8'h11; tick();
        #1 chk("R6 err pulse", 32'(wr_err), 32'd1);
        chk("R6 data kept", 32'(out_dev_data), 32'hC3);
        out_dev_accept = 1; tick();
        #1 chk("R6 err one cycle", 32'(wr_err), 32'd0);
        chk("R7 valid low", 32'(out_dev_valid), 32'd0);
        out_dev_accept = 1; tick();   // R7: accept with nothing pending

        // R9: set and clear together -> clear wins; set alone -> irq via output flag (R8)
        cpu_ien_set = 1; cpu_ien_clr = 1; tick();
        #1 chk("R9 clear wins", 32'(irq), 32'd0);
        cpu_ien_set = 1; tick();
        #1 chk("R9 R8 enabled irq", 32'(irq), 32'd1);
        cpu_irq_ack = 1; cpu_ien_set = 1; tick();
        #1 chk("R9 ack clears", 32'(irq), 32'd0);
        // R10 skip tests
        cpu_skip_in = 1; cpu_skip_out = 0; tick();
        cpu_skip_in = 0; cpu_skip_out = 1; tick();

        // seeded random phase
        for (int i = 0; i < 4000; i++) begin
            in_dev_valid   = ($urandom % 2) == 0;
            in_dev_data    = W'($urandom);
            cpu_in_take    = ($urandom % 4) == 0;
            cpu_out_write  = ($urandom % 3) == 0;
            cpu_acc        = W'($urandom);
            out_dev_accept = ($urandom % 3) == 0;
            cpu_ien_set    = ($urandom % 8) == 0;
            cpu_ien_clr    = ($urandom % 20) == 0;
            cpu_irq_ack    = irq && (($urandom % 6) == 0);
            cpu_skip_in    = ($urandom % 3) == 0;
            cpu_skip_out   = ($urandom % 3) == 0;
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule